// File: doc/BRIEF.md
# Floating-Point Exception Status and Enable Register

This block keeps the floating-point status and control state of a processor core. It decides whether a completed floating-point instruction must trap. The arithmetic unit pulses `op_valid` when a floating-point instruction completes. With that pulse it supplies five per-instruction cause signals and one flag that is set when any source operand was a quiet NaN or an infinity.

On each such pulse the block does three things:
- It overwrites the cause field.
- It accumulates the cause into sticky flags.
- It raises an exception request to the CPU if an enabled class occurred.

A separate mode bit, combined with the invalid-class enable, makes special source operands trap on their own, whatever the result was.

Software sees the whole state as one register word. It reads the word at `csr_rd` and replaces it with a single-cycle write. Bit positions of the word are parameters.

The five classes are indexed the same way in every field: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. With the default parameters the register word is laid out as follows. All other bits read as zero.

| Bits | Field |
|------|-------|
| [4:0] | sticky flags |
| [12:8] | enables |
| [20:16] | cause |
| 24 | special-source trap mode |

Top module: `fpx_status_ctl`

## Requirements
- R1: After reset, `csr_rd` reads 0 and `exc_req` is 0.
- R2: A cycle with `op_valid` high and no software write loads the cause field (default bits [20:16]) with `op_cause`, replacing its previous value.
- R3: A cycle with `op_valid` high and no software write sets the sticky flags (default bits [4:0]) to their old value OR `op_cause`. This happens whether or not a request is raised, and no flag is ever cleared by an operation.
- R4: A cycle with neither `op_valid` nor `sw_wr_en` leaves the cause, flag, enable and mode fields unchanged, and `exc_req` is 0 in the following cycle.
- R5: A software write replaces the flag, enable (default bits [12:8]), cause and mode (default bit 24) fields with the corresponding bits of `sw_wr_data`. Bits outside these fields read 0.
- R6: One cycle after an operation, `exc_req` is 1 if any bit of `op_cause` has its enable set.
- R7: One cycle after an operation with `op_src_special` high, `exc_req` is 1 when both the invalid enable (bit 4 of the enable field) and the mode bit are set. Special operands alone cause no request if either bit is clear.
- R8: `exc_req` is a single-cycle pulse that follows only an `op_valid` cycle. When a write and an operation coincide, the write decides the new register contents. The request is still evaluated with the enables and mode in force before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A floating-point instruction completed this cycle |
| op_cause | input | 5 | Exception classes the instruction raised |
| op_src_special | input | 1 | A source operand was a quiet NaN or an infinity |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_data | input | 32 | Software write value |
| csr_rd | output | 32 | Current register word |
| exc_req | output | 1 | Exception request pulse to the CPU |

## Verification
The bench builds the block with its default field positions and the registered request variant. This keeps the five-class space small enough to walk completely. Every enable pattern, mode setting, special-operand setting and cause pattern is combined, giving 4096 cases. Each case checks the request and the full register word against values computed from the requirements. Targeted sequences add flag accumulation across operations, idle hold, full-width writes, and a write that coincides with an operation.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int NCLS = 5;

   typedef enum int {
      CLS_INEXACT  = 0,
      CLS_UNDER    = 1,
      CLS_OVER     = 2,
      CLS_DIVZERO  = 3,
      CLS_INVALID  = 4
   } cls_idx_e;

   typedef logic [NCLS-1:0] cls_vec_t;
endpackage

// File: rtl/fpx_state_reg.sv
module fpx_state_reg
   import fpx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     op_valid,
   input  cls_vec_t op_cause,
   input  logic     wr_en,
   input  cls_vec_t wr_cause,
   input  cls_vec_t wr_flag,
   input  cls_vec_t wr_ena,
   input  logic     wr_qmode,
   output cls_vec_t cause_q,
   output cls_vec_t flag_q,
   output cls_vec_t ena_q,
   output logic     qmode_q
);
   // per-class status bits; a write has priority over an operation
   for (genvar k = 0; k < NCLS; k++) begin : g_cls
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cause_q[k] <= 1'b0;
            flag_q[k]  <= 1'b0;
         end else if (wr_en) begin
            cause_q[k] <= wr_cause[k];
            flag_q[k]  <= wr_flag[k];
         end else if (op_valid) begin
            cause_q[k] <= op_cause[k];
            flag_q[k]  <= flag_q[k] | op_cause[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q   <= '0;
         qmode_q <= 1'b0;
      end else if (wr_en) begin
         ena_q   <= wr_ena;
         qmode_q <= wr_qmode;
      end
   end

   // R2
   cause_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && !$past(wr_en) && $past(rst_n)) |-> (cause_q == $past(op_cause)));
   // R3
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && !$past(wr_en) && $past(rst_n)) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(op_valid) && !$past(wr_en) && $past(rst_n)) |->
         ($stable(cause_q) && $stable(flag_q) && $stable(ena_q) && $stable(qmode_q)));
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
   import fpx_pkg::*;
#(
   parameter int INV_IDX = 4,
   parameter bit REQ_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     op_valid,
   input  cls_vec_t op_cause,
   input  logic     op_src_special,
   input  cls_vec_t ena,
   input  logic     qmode,
   output logic     exc_req
);
   logic hit_cls, hit_src, trap_now;

   assign hit_cls  = |(op_cause & ena);
   assign hit_src  = op_src_special & qmode & ena[INV_IDX];
   assign trap_now = op_valid & (hit_cls | hit_src);

   if (REQ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) exc_req <= 1'b0;
         else        exc_req <= trap_now;
      end

      // R8
      req_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
         exc_req |-> $past(op_valid));
      // R6
      req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(op_valid) && $past(rst_n) && (($past(op_cause) & $past(ena)) != '0)) |-> exc_req);
      // R7
      req_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(op_valid) && $past(rst_n) && ($past(op_cause) & $past(ena)) == '0
          && !($past(qmode) && $past(ena[INV_IDX]))) |-> !exc_req);
   end else begin : g_comb
      assign exc_req = trap_now;

      // R8
      req_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         exc_req |-> op_valid);
   end
endmodule

// File: rtl/fpx_status_ctl.sv
module fpx_status_ctl
   import fpx_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int FLAG_LSB  = 0,
   parameter int ENA_LSB   = 8,
   parameter int CAUSE_LSB = 16,
   parameter int QMODE_BIT = 24,
   parameter bit REQ_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [NCLS-1:0]  op_cause,
   input  logic             op_src_special,
   input  logic             sw_wr_en,
   input  logic [REG_W-1:0] sw_wr_data,
   output logic [REG_W-1:0] csr_rd,
   output logic             exc_req
);
   localparam logic [REG_W-1:0] CLS_ONES  = REG_W'((1 << NCLS) - 1);
   localparam logic [REG_W-1:0] USED_MASK = (CLS_ONES << FLAG_LSB) | (CLS_ONES << ENA_LSB)
                                          | (CLS_ONES << CAUSE_LSB) | (REG_W'(1) << QMODE_BIT);

   // elaboration checks on the field layout
   if (FLAG_LSB + NCLS > REG_W || ENA_LSB + NCLS > REG_W ||
       CAUSE_LSB + NCLS > REG_W || QMODE_BIT >= REG_W) begin : g_bad_fit
      $error("fpx_status_ctl: a field lies outside the register word");
   end
   if ($countones(USED_MASK) != 3 * NCLS + 1) begin : g_bad_overlap
      $error("fpx_status_ctl: register fields overlap");
   end

   cls_vec_t cause_q, flag_q, ena_q;
   logic     qmode_q;
   logic     unused_wr_bits;

   assign unused_wr_bits = ^(sw_wr_data & ~USED_MASK);

   fpx_state_reg u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_cause (op_cause),
      .wr_en    (sw_wr_en),
      .wr_cause (sw_wr_data[CAUSE_LSB +: NCLS]),
      .wr_flag  (sw_wr_data[FLAG_LSB +: NCLS]),
      .wr_ena   (sw_wr_data[ENA_LSB +: NCLS]),
      .wr_qmode (sw_wr_data[QMODE_BIT]),
      .cause_q  (cause_q),
      .flag_q   (flag_q),
      .ena_q    (ena_q),
      .qmode_q  (qmode_q)
   );

   fpx_trap_eval #(
      .INV_IDX (CLS_INVALID),
      .REQ_REG (REQ_REG)
   ) u_trap (
      .clk            (clk),
      .rst_n          (rst_n),
      .op_valid       (op_valid),
      .op_cause       (op_cause),
      .op_src_special (op_src_special),
      .ena            (ena_q),
      .qmode          (qmode_q),
      .exc_req        (exc_req)
   );

   always_comb begin
      csr_rd                       = '0;
      csr_rd[FLAG_LSB +: NCLS]     = flag_q;
      csr_rd[ENA_LSB +: NCLS]      = ena_q;
      csr_rd[CAUSE_LSB +: NCLS]    = cause_q;
      csr_rd[QMODE_BIT]            = qmode_q;
   end

   // R5
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd & ~USED_MASK) == '0);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (csr_rd == '0));
endmodule

// File: tb/sim_fpx_status_ctl.sv
module sim_fpx_status_ctl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_cause = '0;
   logic        op_src_special = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [31:0] sw_wr_data = '0;
   logic [31:0] csr_rd;
   logic        exc_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_status_ctl u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cause(op_cause),
      .op_src_special(op_src_special), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .csr_rd(csr_rd), .exc_req(exc_req)
   );

   function automatic logic [31:0] word(input logic [4:0] fl, input logic [4:0] en,
                                        input logic [4:0] ca, input logic qm);
      return {7'd0, qm, 3'd0, ca, 3'd0, en, 3'd0, fl};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // inputs change at the falling edge; results are read at the next falling edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_write(input logic [31:0] d);
      sw_wr_en = 1'b1; sw_wr_data = d;
      step();
      sw_wr_en = 1'b0; sw_wr_data = '0;
   endtask

   task automatic do_op(input logic [4:0] c, input logic s);
      op_valid = 1'b1; op_cause = c; op_src_special = s;
      step();
      op_valid = 1'b0; op_cause = '0; op_src_special = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_w;
      logic        exp_r;
      logic [4:0]  acc;
      step(); step();
      rst_n = 1'b1;
      // R1
      chk(csr_rd == 32'd0, "R1", csr_rd, 32'd0);
      chk(exc_req == 1'b0, "R1", {31'd0, exc_req}, 32'd0);

      // R5: full write, unused bits stay zero
      do_write(32'hFFFF_FFFF);
      chk(csr_rd == 32'h011F_1F1F, "R5", csr_rd, 32'h011F_1F1F);
      do_write(word(5'h0A, 5'h11, 5'h05, 1'b0));
      chk(csr_rd == word(5'h0A, 5'h11, 5'h05, 1'b0), "R5", csr_rd, word(5'h0A, 5'h11, 5'h05, 1'b0));

      // R3 accumulation and R2 replacement, no enables
      do_write(32'd0);
      acc = '0;
      for (int i = 0; i < 5; i++) begin
         logic [4:0] c;
         c = 5'(1 << i) | 5'(i);
         do_op(c, 1'b0);
         acc = acc | c;
         chk(csr_rd == word(acc, 5'd0, c, 1'b0), "R3", csr_rd, word(acc, 5'd0, c, 1'b0));
         chk(exc_req == 1'b0, "R6", {31'd0, exc_req}, 32'd0);
      end
      do_op(5'd0, 1'b0);
      chk(csr_rd == word(acc, 5'd0, 5'd0, 1'b0), "R2", csr_rd, word(acc, 5'd0, 5'd0, 1'b0));

      // R4 idle hold with enables set
      do_write(word(5'h03, 5'h1F, 5'h14, 1'b1));
      for (int i = 0; i < 3; i++) begin
         op_cause = 5'h1F; op_src_special = 1'b1;   // ignored without op_valid
         step();
         chk(csr_rd == word(5'h03, 5'h1F, 5'h14, 1'b1), "R4", csr_rd, word(5'h03, 5'h1F, 5'h14, 1'b1));
         chk(exc_req == 1'b0, "R4", {31'd0, exc_req}, 32'd0);
      end
      op_cause = '0; op_src_special = 1'b0;

      // R8: write and op together; request uses pre-write enables
      op_valid = 1'b1; op_cause = 5'h1C;
      sw_wr_en = 1'b1; sw_wr_data = word(5'h01, 5'h00, 5'h00, 1'b0);
      step();
      op_valid = 1'b0; op_cause = '0; sw_wr_en = 1'b0; sw_wr_data = '0;
      chk(csr_rd == word(5'h01, 5'h00, 5'h00, 1'b0), "R8", csr_rd, word(5'h01, 5'h00, 5'h00, 1'b0));
      chk(exc_req == 1'b1, "R8", {31'd0, exc_req}, 32'd1);
      step();
      chk(exc_req == 1'b0, "R8", {31'd0, exc_req}, 32'd0);

      // R6 / R7 exhaustive sweep
      for (int e = 0; e < 32; e++) begin
         for (int q = 0; q < 2; q++) begin
            for (int s = 0; s < 2; s++) begin
               for (int c = 0; c < 32; c++) begin
                  do_write(word(5'd0, 5'(e), 5'd0, 1'(q)));
                  chk(exc_req == 1'b0, "R8", {31'd0, exc_req}, 32'd0);
                  do_op(5'(c), 1'(s));
                  exp_r = ((c & e) != 0) || (e[4] && q == 1 && s == 1);
                  exp_w = word(5'(c), 5'(e), 5'(c), 1'(q));
                  if ((c & e) != 0)
                     chk(exc_req == exp_r, "R6", {31'd0, exc_req}, {31'd0, exp_r});
                  else
                     chk(exc_req == exp_r, "R7", {31'd0, exc_req}, {31'd0, exp_r});
                  chk(csr_rd == exp_w, "R3", csr_rd, exp_w);
               end
            end
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule